// File: doc/BRIEF.md
# Edge Time-Stamp Capture Unit

This block records when an edge arrives on an external event line. At a qualifying edge it copies the value of a free-running timer count into a capture register and raises a capture flag. An interrupt request follows the flag when both a local enable and a global enable are set. A multiplexer picks the event source, either a board input or an on-chip comparator output. A two-flop synchronizer follows the multiplexer. An optional majority-free persistence filter comes next, and then a polarity-selectable edge detector.

The timer itself lives outside the block and supplies its count and a "reached TOP" strobe. Sometimes the surrounding timer uses the capture register as its period limit. In that case the block stops taking captures, and the flag instead marks each arrival at TOP. Software can load the capture register directly so that it can serve as that limit. Software clears the flag by writing a one to it, or through an interrupt-acknowledge strobe.

Top module: `icap_unit`

## Requirements
- R1: After reset the capture register reads 0, the flag reads 0 and the interrupt request is low. The synchronizer and filter also start at a low level.
- R2: With `edge_rise`=1 only a low-to-high transition of the selected source captures. With `edge_rise`=0 only a high-to-low transition captures. The other direction changes neither the capture register nor the flag.
- R3: With the filter off, a change of the selected source is first sampled at some clock edge; call it edge 1. The capture register is loaded at edge 3 with the `cnt_val` present just before edge 3, and the flag is set at that same edge 3.
- R4: With `filt_en`=1 the filtered level changes only after four successive synchronized samples agree. This moves the capture to edge 7. A pulse lasting three clock cycles produces no capture.
- R5: `src_sel`=0 selects `pin_in` and `src_sel`=1 selects `cmp_in`. Transitions on the unselected input have no effect.
- R6: While `top_is_cap`=1 the source is ignored and the capture register keeps its value apart from CPU writes. In this mode the flag is set at each clock edge where `cnt_at_top` is high.
- R7: `irq_ack` or `flag_wr_one` high at a clock edge clears the flag at that edge. If a set condition occurs at the same edge, the set wins and the flag stays 1.
- R8: `cap_wr_en` at a clock edge loads `cap_wr_data` into the capture register. If a capture occurs at the same edge, the captured count is kept and the write is dropped.
- R9: `irq` is high exactly when the flag, `irq_en` and `gie` are all 1. It follows a change of the enables within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External event line (asynchronous) |
| cmp_in | input | 1 | Comparator output event line (asynchronous) |
| src_sel | input | 1 | Source choice: 0 pin, 1 comparator |
| filt_en | input | 1 | Enables the four-sample persistence filter |
| edge_rise | input | 1 | 1 selects rising edges, 0 selects falling edges |
| top_is_cap | input | 1 | Timer uses the capture register as TOP; captures are off |
| cnt_val | input | W | Current timer count |
| cnt_at_top | input | 1 | Timer is at TOP this cycle |
| cap_wr_en | input | 1 | CPU write strobe for the capture register |
| cap_wr_data | input | W | CPU write data for the capture register |
| flag_wr_one | input | 1 | CPU writes one to the flag (clears it) |
| irq_ack | input | 1 | Interrupt acknowledge strobe (clears the flag) |
| irq_en | input | 1 | Capture interrupt enable |
| gie | input | 1 | Global interrupt enable |
| cap_val | output | W | Capture register |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
A source change driven at a falling clock edge is due in the capture register and flag at the third following rising edge without the filter, and at the seventh with it. The bench confirms the old value at the falling edge just before that point. It takes the expected count at that falling edge and compares shortly after the due rising edge. Flag clears, CPU writes and TOP-driven flag sets are due one rising edge after the strobe, and the interrupt request is checked combinationally a nanosecond after the enables move. Cases that must not capture are checked at the due edge and again several cycles later.

// File: rtl/icap_pkg.sv
package icap_pkg;
    // Source selection encoding (R5)
    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_CMP = 1'b1
    } icap_src_e;

    localparam int SYNC_STAGES_DEF = 2;
    localparam int FILT_DEPTH_DEF  = 4;
    localparam int CNT_W_DEF       = 16;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;   // R1: starts low
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    output logic q
);
    localparam int HW = DEPTH - 1;

    typedef struct packed {
        logic [HW-1:0] hist;
        logic          lvl;
    } filt_s;

    filt_s st_d, st_q;
    logic [DEPTH-1:0] window;

    // R4: the level moves only when every sample in the window agrees
    always_comb begin
        window    = {st_q.hist, d};
        st_d      = st_q;
        st_d.hist = window[HW-1:0];
        if (!en)              st_d.lvl = d;
        else if (&window)     st_d.lvl = 1'b1;
        else if (~|window)    st_d.lvl = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // bypass adds no delay when the filter is off
    assign q = en ? st_q.lvl : d;
endmodule

// File: rtl/icap_edge.sv
module icap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_sel,
    input  logic enable,
    output logic evt
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        // R2: polarity decides which transition counts
        evt    = enable && (lvl != prev_q) && (lvl == rise_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int W           = CNT_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF,
    parameter int FILT_DEPTH  = FILT_DEPTH_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin_in,
    input  logic         cmp_in,
    input  logic         src_sel,
    input  logic         filt_en,
    input  logic         edge_rise,
    input  logic         top_is_cap,
    input  logic [W-1:0] cnt_val,
    input  logic         cnt_at_top,
    input  logic         cap_wr_en,
    input  logic [W-1:0] cap_wr_data,
    input  logic         flag_wr_one,
    input  logic         irq_ack,
    input  logic         irq_en,
    input  logic         gie,
    output logic [W-1:0] cap_val,
    output logic         cap_flag,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] cap;
        logic         flag;
    } core_s;

    core_s st_d, st_q;
    logic  src_raw, src_sync, src_lvl, cap_evt;
    logic  set_flag, clr_flag;

    // R5: source multiplexer
    always_comb begin
        src_raw = (icap_src_e'(src_sel) == SRC_CMP) ? cmp_in : pin_in;
    end

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_raw),
        .q     (src_sync)
    );

    icap_filter #(.DEPTH(FILT_DEPTH)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (filt_en),
        .d     (src_sync),
        .q     (src_lvl)
    );

    // R6: detection is switched off while the capture register is TOP
    icap_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (src_lvl),
        .rise_sel (edge_rise),
        .enable   (!top_is_cap),
        .evt      (cap_evt)
    );

    always_comb begin
        st_d     = st_q;
        set_flag = cap_evt || (top_is_cap && cnt_at_top);
        clr_flag = irq_ack || flag_wr_one;
        // R8: a capture outranks a CPU write
        if (cap_evt)        st_d.cap = cnt_val;
        else if (cap_wr_en) st_d.cap = cap_wr_data;
        // R7: set outranks clear
        if (set_flag)       st_d.flag = 1'b1;
        else if (clr_flag)  st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;   // R1
        else        st_q <= st_d;
    end

    assign cap_val  = st_q.cap;
    assign cap_flag = st_q.flag;
    assign irq      = st_q.flag && irq_en && gie;   // R9
endmodule

// File: rtl/icap_chk.sv
module icap_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cap_evt,
    input logic [W-1:0] cnt_val,
    input logic [W-1:0] cap_val,
    input logic         cap_flag,
    input logic         cap_wr_en,
    input logic [W-1:0] cap_wr_data,
    input logic         top_is_cap,
    input logic         cnt_at_top,
    input logic         flag_wr_one,
    input logic         irq_ack
);
    assert_capture_copies_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_val == $past(cnt_val)) && cap_flag);

    assert_write_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_wr_en && !cap_evt) |=> (cap_val == $past(cap_wr_data)));

    assert_top_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (top_is_cap && !cap_wr_en) |=> $stable(cap_val));

    assert_top_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cap_flag) && $past(top_is_cap)) |-> $past(cnt_at_top));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_ack || flag_wr_one) && !cap_evt && !(top_is_cap && cnt_at_top)) |=> !cap_flag);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt || (top_is_cap && cnt_at_top)) |=> cap_flag);
endmodule

bind icap_unit icap_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_evt     (cap_evt),
    .cnt_val     (cnt_val),
    .cap_val     (cap_val),
    .cap_flag    (cap_flag),
    .cap_wr_en   (cap_wr_en),
    .cap_wr_data (cap_wr_data),
    .top_is_cap  (top_is_cap),
    .cnt_at_top  (cnt_at_top),
    .flag_wr_one (flag_wr_one),
    .irq_ack     (irq_ack)
);

// File: tb/sim_icap_unit.sv
module sim_icap_unit;
    localparam int W = 16;
    localparam int NV = 10;
    // fields: {src_sel, drive_cmp, edge_rise, filt_en, idle_level}
    localparam logic [4:0] VEC [NV] = '{
        5'b00100, 5'b00001, 5'b00101, 5'b00000, 5'b00110,
        5'b00011, 5'b11100, 5'b10100, 5'b01100, 5'b11011
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic pin_in = 0, cmp_in = 0, src_sel = 0, filt_en = 0, edge_rise = 0;
    logic top_is_cap = 0, cnt_at_top = 0, cap_wr_en = 0, flag_wr_one = 0;
    logic irq_ack = 0, irq_en = 0, gie = 0;
    logic [W-1:0] cnt_val, cap_wr_data = '0, cap_val, old, expv;
    logic cap_flag, irq;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    icap_unit #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cmp_in(cmp_in),
        .src_sel(src_sel), .filt_en(filt_en), .edge_rise(edge_rise),
        .top_is_cap(top_is_cap), .cnt_val(cnt_val), .cnt_at_top(cnt_at_top),
        .cap_wr_en(cap_wr_en), .cap_wr_data(cap_wr_data),
        .flag_wr_one(flag_wr_one), .irq_ack(irq_ack), .irq_en(irq_en),
        .gie(gie), .cap_val(cap_val), .cap_flag(cap_flag), .irq(irq)
    );

    initial begin
        cnt_val = 16'h0100;
        forever begin
            @(negedge clk);
            cnt_val = cnt_val + 16'd1;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_wr_one = 1;
        @(negedge clk); flag_wr_one = 0;
    endtask

    task automatic settle(input logic lvl);
        @(negedge clk); pin_in = lvl; cmp_in = lvl;
        repeat (12) @(negedge clk);
        clear_flag();
        @(negedge clk); old = cap_val;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cap_val == 0, "R1 cap", cap_val, 0);
        chk(cap_flag == 0, "R1 flag", cap_flag, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(cap_val == 0 && cap_flag == 0, "R1 after release", {cap_val, cap_flag}, 0);

        // table walk: R2, R3, R4, R5
        for (int i = 0; i < NV; i++) begin
            logic s, dc, er, fe, idl, hit;
            int lat;
            {s, dc, er, fe, idl} = VEC[i];
            src_sel = s; edge_rise = er; filt_en = fe;
            settle(idl);
            hit = (s == dc) && ((~idl) == er);
            lat = fe ? 7 : 3;
            @(negedge clk);
            if (dc) cmp_in = ~idl; else pin_in = ~idl;
            repeat (lat - 1) @(negedge clk);
            chk(cap_val == old && !cap_flag, "R3/R4 not early", cap_val, old);
            #1 expv = cnt_val;
            @(posedge clk); #2;
            if (hit) begin
                chk(cap_val == expv, "R2/R3/R4/R5 captured value", cap_val, expv);
                chk(cap_flag == 1, "R3 flag set", cap_flag, 1);
            end else begin
                chk(cap_val == old, "R2/R5 ignored value", cap_val, old);
                chk(cap_flag == 0, "R2/R5 ignored flag", cap_flag, 0);
                repeat (6) @(negedge clk);
                chk(cap_val == old && !cap_flag, "R2/R5 still ignored", cap_val, old);
            end
        end

        // R4: three-cycle glitch rejected by the filter
        src_sel = 0; edge_rise = 1; filt_en = 1;
        settle(0);
        @(negedge clk); pin_in = 1;
        repeat (3) @(negedge clk);
        pin_in = 0;
        repeat (12) @(negedge clk);
        chk(cap_val == old && !cap_flag, "R4 glitch", cap_val, old);

        // R8: write collides with capture; capture wins
        filt_en = 0;
        settle(0);
        @(negedge clk); pin_in = 1;
        repeat (2) @(negedge clk);
        cap_wr_en = 1; cap_wr_data = 16'h1234;
        #1 expv = cnt_val;
        @(posedge clk); #2;
        chk(cap_val == expv, "R8 capture beats write", cap_val, expv);
        @(negedge clk); cap_wr_en = 0;

        // R8: plain CPU write
        @(negedge clk); cap_wr_en = 1; cap_wr_data = 16'hBEEF;
        @(negedge clk); cap_wr_en = 0;
        chk(cap_val == 16'hBEEF, "R8 write", cap_val, 16'hBEEF);

        // R6: capture register as TOP; source ignored
        settle(0);
        top_is_cap = 1;
        @(negedge clk); pin_in = 1;
        repeat (10) @(negedge clk);
        chk(cap_val == old, "R6 no capture", cap_val, old);
        chk(cap_flag == 0, "R6 no flag from edge", cap_flag, 0);
        @(negedge clk); cnt_at_top = 1;
        @(negedge clk); cnt_at_top = 0;
        chk(cap_flag == 1, "R6 flag at TOP", cap_flag, 1);
        chk(cap_val == old, "R6 value kept", cap_val, old);

        // R9: interrupt gating
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); irq_en = k[0]; gie = k[1];
            #1 chk(irq == (k == 3), "R9 irq gate", irq, (k == 3));
        end

        // R7: acknowledge clears
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
        chk(cap_flag == 0, "R7 ack clears", cap_flag, 0);
        chk(irq == 0, "R9 irq drops", irq, 0);

        // R7: set and clear together; set wins
        @(negedge clk); cnt_at_top = 1; flag_wr_one = 1;
        @(negedge clk); cnt_at_top = 0; flag_wr_one = 0;
        chk(cap_flag == 1, "R7 set wins", cap_flag, 1);
        @(negedge clk); flag_wr_one = 1;
        @(negedge clk); flag_wr_one = 0;
        chk(cap_flag == 0, "R7 write-one clears", cap_flag, 0);

        // R8: write works while in TOP mode
        @(negedge clk); cap_wr_en = 1; cap_wr_data = 16'h00FF;
        @(negedge clk); cap_wr_en = 0;
        chk(cap_val == 16'h00FF, "R8 write in TOP mode", cap_val, 16'h00FF);
        top_is_cap = 0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule